// File: doc/BRIEF.md
# Arrow Sign Build-Up Sequencer

This block animates a five-lamp arrow sign. While a run switch is on, the lamps light group by group: first the pair nearest the tail, then the middle pair as well, then the single tip lamp as well. After that the whole sign goes dark and the pattern starts again. Each step lasts one clock period, so the clock that drives the block also sets the blink rate.

The controller is a Moore machine with a small step counter. The lamp drives depend only on that counter and never on the switch directly. Turning the switch off does not freeze the sign. The next clock edge sends it to the dark step, and the build-up starts from the beginning when the switch comes back on. A synchronous, active-high reset also sends the machine to the dark step.

The lamp drives are registered. The register input is decoded from the next step value, so the lamps switch at the same edge as the step counter and add no cycle of latency.

Top module: `arrow_sign_ctrl`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, all bits of `lamp_grp` are 0 after that edge, whatever the switch and the previous step.
- R2: With `run_sw` at 1, the sign moves one step at each rising edge through the lamp patterns 000, 001, 011, 111 and then back to 000, and this repeats.
- R3: When `run_sw` is 0 at a rising edge, `lamp_grp` is 000 after that edge, whatever step the sign was in.
- R4: Bit 0 of `lamp_grp` drives lamps 1 and 2, bit 1 drives lamps 3 and 4, and bit 2 drives lamp 5. The dark step shows 000, the first step 001, the second 011 and the last 111.
- R5: `lamp_grp` changes only at rising clock edges. A change on `run_sw` between edges leaves the lamps unchanged until the next edge.
- R6: A higher lamp group is never lit unless every lower group is lit too.
- R7: While `run_sw` stays at 0, `lamp_grp` stays at 000 across any number of edges.
- R8: After the sign has been forced dark, the first edge with `run_sw` at 1 lights only bit 0. The pattern restarts from the beginning and does not resume where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock. One step is taken per rising edge. |
| rst | input | 1 | Synchronous reset, active high. Forces the dark step. |
| run_sw | input | 1 | Run switch. 1 lets the pattern run; 0 sends the sign dark at the next edge. |
| lamp_grp | output | NUM_GROUPS (3) | Registered lamp-group drives. Bit 0 is lamps 1–2, bit 1 is lamps 3–4, bit 2 is lamp 5. |

## Verification
The bench drops the switch in each of the four steps in turn. A design that paused or backed up one step, instead of going dark, would leave lamps lit after that edge. It also runs three full laps, to catch a counter that sticks at the last step or skips the wrap back to dark. It toggles the switch halfway through a clock period to expose lamp logic that decodes the switch combinationally. Finally, it restarts after a drop to show that the build-up begins again at the first pair and does not resume mid-pattern.

// File: rtl/arrow_sign_pkg.sv
package arrow_sign_pkg;
  // Default number of lamp groups on the sign (tail pair, middle pair, tip)
  localparam int DEF_GROUPS = 3;

  // Readable names for the default four-step sequence
  typedef enum logic [1:0] {
    PH_DARK = 2'b00,
    PH_TAIL = 2'b01,
    PH_MID  = 2'b10,
    PH_FULL = 2'b11
  } sign_phase_t;
endpackage

// File: rtl/sign_step_next.sv
module sign_step_next #(
  parameter int ST_W      = 2,
  parameter int LAST_STEP = 3
) (
  input  logic [ST_W-1:0] step_q,
  input  logic            run_sw,
  output logic [ST_W-1:0] step_d
);
  always_comb begin
    if (!run_sw)
      step_d = '0;
    else if (step_q == ST_W'(LAST_STEP))
      step_d = '0;
    else
      step_d = step_q + ST_W'(1);
  end
endmodule

// File: rtl/sign_step_reg.sv
module sign_step_reg #(
  parameter int ST_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] step_d,
  output logic [ST_W-1:0] step_q
);
  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/sign_lamp_dec.sv
module sign_lamp_dec #(
  parameter int ST_W       = 2,
  parameter int NUM_GROUPS = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ST_W-1:0]       step_d,
  output logic [NUM_GROUPS-1:0] lamp_q
);
  logic [NUM_GROUPS-1:0] lamp_d;

  // Group g is lit once the step index has passed g (thermometer decode)
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign lamp_d[g] = (step_d > ST_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) lamp_q <= '0;
    else     lamp_q <= lamp_d;
  end
endmodule

// File: rtl/arrow_sign_ctrl.sv
module arrow_sign_ctrl #(
  parameter int NUM_GROUPS = arrow_sign_pkg::DEF_GROUPS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_sw,
  output logic [NUM_GROUPS-1:0] lamp_grp
);
  localparam int NUM_STEPS = NUM_GROUPS + 1;
  localparam int ST_W      = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam int LAST_STEP = NUM_STEPS - 1;

  logic [ST_W-1:0] step_q;
  logic [ST_W-1:0] step_d;

  sign_step_next #(.ST_W(ST_W), .LAST_STEP(LAST_STEP)) u_next (
    .step_q (step_q),
    .run_sw (run_sw),
    .step_d (step_d)
  );

  sign_step_reg #(.ST_W(ST_W)) u_reg (
    .clk    (clk),
    .rst    (rst),
    .step_d (step_d),
    .step_q (step_q)
  );

  sign_lamp_dec #(.ST_W(ST_W), .NUM_GROUPS(NUM_GROUPS)) u_dec (
    .clk    (clk),
    .rst    (rst),
    .step_d (step_d),
    .lamp_q (lamp_grp)
  );
endmodule

// File: rtl/arrow_sign_chk.sv
module arrow_sign_chk #(
  parameter int NUM_GROUPS = arrow_sign_pkg::DEF_GROUPS
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  run_sw,
  input logic [NUM_GROUPS-1:0] lamp_grp
);
  logic                  rst_q;
  logic [NUM_GROUPS-1:0] after_step;

  always_ff @(posedge clk) rst_q <= rst;

  // Pattern one step further on, taken from the lamps as seen at the port
  always_comb begin
    if (&lamp_grp) after_step = '0;
    else           after_step = {lamp_grp[NUM_GROUPS-2:0], 1'b1};
  end

  // R1: an edge with reset high leaves the sign dark
  always @(negedge clk) begin
    if (rst_q) begin
      a_r1_reset_dark: assert (lamp_grp == '0)
        else $error("R1 lamps %b after reset edge", lamp_grp);
    end
  end

  // R2: running switch advances the build-up pattern by one step
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    run_sw |=> lamp_grp == $past(after_step));

  // R3 / R7: switch off at an edge gives dark after it
  a_r3_drop_dark: assert property (@(posedge clk) disable iff (rst)
    !run_sw |=> lamp_grp == '0);

  // R6: groups light cumulatively
  a_r6_cumulative: assert property (@(posedge clk) disable iff (rst)
    (lamp_grp[NUM_GROUPS-1:1] & ~lamp_grp[NUM_GROUPS-2:0]) == '0);

  // R8: restart from dark lights only the first group
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    (run_sw && lamp_grp == '0) |=> $onehot0(lamp_grp) && lamp_grp[0]);
endmodule

bind arrow_sign_ctrl arrow_sign_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run_sw   (run_sw),
  .lamp_grp (lamp_grp)
);

// File: tb/tb_arrow_sign_ctrl.sv
module tb_arrow_sign_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_sw = 1'b0;
  logic [2:0] lamp_grp;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  arrow_sign_ctrl dut (
    .clk      (clk),
    .rst      (rst),
    .run_sw   (run_sw),
    .lamp_grp (lamp_grp)
  );

  function automatic logic [2:0] pat(input int s);
    return {s == 3, s >= 2, s >= 1};
  endfunction

  task automatic chk(input logic [2:0] exp, input string tag);
    vecs++;
    if (lamp_grp !== exp) begin
      errs++;
      $display("FAIL %s: lamps=%b expected %b", tag, lamp_grp, exp);
    end
  endtask

  // Wait for a rising edge, then settle 2 ns past it
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    run_sw = 1'b0;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(3'b000, "R1 reset state");
  endtask

  task automatic t_laps();
    do_reset();
    run_sw = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      chk(pat(i % 4), "R2/R4/R6 lap sequence");
    end
  endtask

  task automatic t_drop_each();
    for (int s = 0; s < 4; s++) begin
      do_reset();
      run_sw = 1'b1;
      for (int k = 0; k < s + 4; k++) tick();  // one lap, then s steps
      chk(pat(s), "R2 reach step before drop");
      run_sw = 1'b0;
      tick();
      chk(3'b000, "R3 drop from step");
    end
  endtask

  task automatic t_hold_dark();
    do_reset();
    run_sw = 1'b1;
    tick();
    tick();
    run_sw = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(3'b000, "R7 held dark");
    end
  endtask

  task automatic t_mid_toggle();
    do_reset();
    run_sw = 1'b1;
    tick();
    tick();
    chk(3'b011, "R4 second step");
    #6 run_sw = 1'b0;   // mid-period
    #6;
    chk(3'b011, "R5 no change between edges");
    tick();
    chk(3'b000, "R3 dark after mid drop");
    #6 run_sw = 1'b1;
    #6;
    chk(3'b000, "R5 no change on mid raise");
    tick();
    chk(3'b001, "R8 restart from first pair");
    tick();
    chk(3'b011, "R8 continues after restart");
  endtask

  task automatic t_reset_running();
    do_reset();
    run_sw = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    chk(3'b111, "R4 full step");
    rst = 1'b1;
    tick();
    chk(3'b000, "R1 reset while running");
    rst = 1'b0;
    tick();
    chk(3'b001, "R8 first step after reset");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_laps();
    t_drop_each();
    t_hold_dark();
    t_mid_toggle();
    t_reset_running();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule